// File: doc/BRIEF.md
# Octet Prefetch Address Sequencer

This block produces the instruction-fetch addresses for a pipelined front end whose memory returns aligned groups of eight words (octets). A fetch pointer runs ahead of execution one whole octet at a time. Each time memory takes a request, the pointer and the address shown to memory both step forward by one octet, so the next request is ready at once. A separate word pointer names the next instruction word to enter the instruction register. It counts up by one word per consumed word and jumps to the fetch pointer's octet when it leaves the last word of an octet.

Four kinds of redirect move the fetch pointer:
- a refetch after a hazard seen at the third pipeline stage;
- the start of a new instruction sequence;
- a branch whose target is not yet in the pipe;
- a loop-back to a saved octet.

A branch, execute or indirect target that already lies in the current octet moves only the word pointer and costs no memory cycle. Every redirect that moves the fetch pointer raises a one-cycle flush strobe for the octet buffers downstream.

Top module: `octet_fetch_seq`

## Requirements
- R1: After reset, mem_req is 0, mem_octet is 0, pa_word is 0 and flush is 0.
- R2: While mem_req is 1 and mem_ack is 1 in a cycle with no far redirect, mem_octet rises by exactly one on the next cycle. mem_octet is always bits 23:3 of the 24-bit fetch address.
- R3: While mem_req is 1 and mem_ack is 0 with no far redirect, mem_req stays 1 and mem_octet stays unchanged.
- R4: A sequence start (seq_start) loads l3_addr into the fetch pointer, the memory address and the word pointer (mem_octet = l3_addr[23:3], pa_word = l3_addr), and mem_req becomes 1 on the next cycle.
- R5: A hazard refetch (hazard_refetch) loads l3_addr the same way as R4, so the octet holding the stage-3 instruction is requested again.
- R6: A far branch (branch_far) loads tgt_addr into the fetch pointer, the memory address and the word pointer, and raises mem_req.
- R7: A near target (target_near) loads only pa_word from tgt_addr. It gives no flush. With no accept and no far redirect in the same cycle, mem_octet is unchanged.
- R8: Each word_take raises pa_word by one. When pa_word[2:0] is 7, pa_word instead loads {fetch octet, 3'b000}, using the fetch octet held before that cycle's edge. This holds even when an accept happens in the same cycle.
- R9: A loop-back (loop_back) loads loop_octet into the fetch pointer and mem_octet and raises mem_req. pa_word does not change.
- R10: When redirects happen together, priority is hazard refetch, then sequence start, then far branch, then loop-back, then sequential advance. Word-pointer loads from far redirects beat target_near, which beats word_take.
- R11: flush is 1 in the cycle after any far redirect (hazard, start, far branch, loop-back) and 0 otherwise.
- R12: An accept in the same cycle as a far redirect is dropped. mem_octet takes the redirect octet, not the advanced one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seq_start | input | 1 | Begin a new instruction sequence at l3_addr |
| hazard_refetch | input | 1 | Refetch the stage-3 instruction at l3_addr |
| l3_addr | input | 24 | Stage-3 instruction address |
| branch_far | input | 1 | Branch to tgt_addr, target not in the pipe |
| target_near | input | 1 | Branch/execute/indirect target inside the current octet |
| tgt_addr | input | 24 | Branch, execute or indirect target word address |
| loop_back | input | 1 | Return to the saved octet |
| loop_octet | input | 21 | Saved loop-back octet address |
| word_take | input | 1 | One word consumed into the instruction register |
| mem_ack | input | 1 | Memory accepts the current request |
| mem_req | output | 1 | Request pending to memory |
| mem_octet | output | 21 | Octet address presented to memory |
| pa_word | output | 24 | Present word address |
| flush | output | 1 | One-cycle flush strobe for octet buffers |

## Verification
The collisions that matter are an accept in the same cycle as a far redirect, and an accept in the same cycle as a word_take that leaves an octet. In the first, the redirect must win and the advance must be lost. In the second, the word pointer must take the fetch octet from before the advance. The bench forces both pairs in directed cycles with worked-out expected addresses. It then drives a long pseudo-random mix in which any of the inputs can coincide. A behavioural model, built on plain arithmetic and the stated priority order, predicts all four outputs, and they are compared on every clock.

// File: rtl/osq_pkg.sv
package osq_pkg;

    typedef enum logic [2:0] {
        RD_NONE   = 3'd0,
        RD_HAZARD = 3'd1,
        RD_START  = 3'd2,
        RD_BRANCH = 3'd3,
        RD_LOOP   = 3'd4
    } redir_e;

    function automatic logic redir_moves_pa(redir_e k);
        return (k == RD_HAZARD) || (k == RD_START) || (k == RD_BRANCH);
    endfunction

endpackage

// File: rtl/osq_redirect_arb.sv
module osq_redirect_arb
    import osq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int OFS_W  = 3,
    localparam int OCT_W = ADDR_W - OFS_W
) (
    input  logic              hazard_refetch,
    input  logic              seq_start,
    input  logic              branch_far,
    input  logic              loop_back,
    input  logic [ADDR_W-1:0] l3_addr,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [OCT_W-1:0]  loop_octet,
    output redir_e            kind,
    output logic [OCT_W-1:0]  redir_oct,
    output logic [ADDR_W-1:0] redir_word,
    output logic              pa_from_redir
);

    always_comb begin
        kind       = RD_NONE;
        redir_oct  = '0;
        redir_word = '0;
        if (hazard_refetch) begin
            kind       = RD_HAZARD;
            redir_oct  = l3_addr[ADDR_W-1:OFS_W];
            redir_word = l3_addr;
        end else if (seq_start) begin
            kind       = RD_START;
            redir_oct  = l3_addr[ADDR_W-1:OFS_W];
            redir_word = l3_addr;
        end else if (branch_far) begin
            kind       = RD_BRANCH;
            redir_oct  = tgt_addr[ADDR_W-1:OFS_W];
            redir_word = tgt_addr;
        end else if (loop_back) begin
            kind       = RD_LOOP;
            redir_oct  = loop_octet;
        end
        pa_from_redir = redir_moves_pa(kind);
    end

endmodule

// File: rtl/osq_fetch_ptr.sv
module osq_fetch_ptr
    import osq_pkg::*;
#(
    parameter int OCT_W = 21
) (
    input  redir_e           kind,
    input  logic [OCT_W-1:0] redir_oct,
    input  logic [OCT_W-1:0] la_q,
    input  logic [OCT_W-1:0] oa_q,
    input  logic             req_q,
    input  logic             mem_ack,
    output logic [OCT_W-1:0] la_d,
    output logic [OCT_W-1:0] oa_d,
    output logic             req_d,
    output logic             flush_d
);

    localparam logic [OCT_W-1:0] ONE_OCT = OCT_W'(1);

    logic             redir;
    logic             advance;
    logic [OCT_W-1:0] la_inc;

    always_comb begin
        redir   = (kind != RD_NONE);
        advance = req_q && mem_ack && !redir;
        la_inc  = la_q + ONE_OCT;
        la_d    = la_q;
        oa_d    = oa_q;
        req_d   = req_q;
        if (redir) begin
            la_d  = redir_oct;
            oa_d  = redir_oct;
            req_d = 1'b1;
        end else if (advance) begin
            la_d = la_inc;
            oa_d = la_inc;
        end
        flush_d = redir;
    end

endmodule

// File: rtl/osq_word_ptr.sv
module osq_word_ptr #(
    parameter int ADDR_W = 24,
    parameter int OFS_W  = 3,
    localparam int OCT_W = ADDR_W - OFS_W
) (
    input  logic [ADDR_W-1:0] pa_q,
    input  logic [OCT_W-1:0]  la_q,
    input  logic              pa_from_redir,
    input  logic [ADDR_W-1:0] redir_word,
    input  logic              target_near,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic              word_take,
    output logic [ADDR_W-1:0] pa_d
);

    localparam logic [OFS_W-1:0] LAST_WORD = '1;

    logic at_last;

    always_comb begin
        at_last = (pa_q[OFS_W-1:0] == LAST_WORD);
        pa_d    = pa_q;
        if (pa_from_redir) begin
            pa_d = redir_word;
        end else if (target_near) begin
            pa_d = tgt_addr;
        end else if (word_take) begin
            pa_d = at_last ? {la_q, {OFS_W{1'b0}}} : pa_q + ADDR_W'(1);
        end
    end

endmodule

// File: rtl/octet_fetch_seq.sv
module octet_fetch_seq
    import osq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int OFS_W  = 3,
    localparam int OCT_W = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_start,
    input  logic              hazard_refetch,
    input  logic [ADDR_W-1:0] l3_addr,
    input  logic              branch_far,
    input  logic              target_near,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic              loop_back,
    input  logic [OCT_W-1:0]  loop_octet,
    input  logic              word_take,
    input  logic              mem_ack,
    output logic              mem_req,
    output logic [OCT_W-1:0]  mem_octet,
    output logic [ADDR_W-1:0] pa_word,
    output logic              flush
);

    typedef struct packed {
        logic [OCT_W-1:0]  la;
        logic [OCT_W-1:0]  oa;
        logic [ADDR_W-1:0] pa;
        logic              req;
        logic              flush;
    } seq_state_t;

    seq_state_t st_d, st_q;

    redir_e            kind;
    logic [OCT_W-1:0]  redir_oct;
    logic [ADDR_W-1:0] redir_word;
    logic              pa_from_redir;
    logic [OCT_W-1:0]  la_nxt, oa_nxt;
    logic [ADDR_W-1:0] pa_nxt;
    logic              req_nxt, flush_nxt;

    osq_redirect_arb #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_arb (
        .hazard_refetch (hazard_refetch),
        .seq_start      (seq_start),
        .branch_far     (branch_far),
        .loop_back      (loop_back),
        .l3_addr        (l3_addr),
        .tgt_addr       (tgt_addr),
        .loop_octet     (loop_octet),
        .kind           (kind),
        .redir_oct      (redir_oct),
        .redir_word     (redir_word),
        .pa_from_redir  (pa_from_redir)
    );

    osq_fetch_ptr #(.OCT_W(OCT_W)) u_fetch (
        .kind      (kind),
        .redir_oct (redir_oct),
        .la_q      (st_q.la),
        .oa_q      (st_q.oa),
        .req_q     (st_q.req),
        .mem_ack   (mem_ack),
        .la_d      (la_nxt),
        .oa_d      (oa_nxt),
        .req_d     (req_nxt),
        .flush_d   (flush_nxt)
    );

    osq_word_ptr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_word (
        .pa_q          (st_q.pa),
        .la_q          (st_q.la),
        .pa_from_redir (pa_from_redir),
        .redir_word    (redir_word),
        .target_near   (target_near),
        .tgt_addr      (tgt_addr),
        .word_take     (word_take),
        .pa_d          (pa_nxt)
    );

    always_comb begin
        st_d       = st_q;
        st_d.la    = la_nxt;
        st_d.oa    = oa_nxt;
        st_d.pa    = pa_nxt;
        st_d.req   = req_nxt;
        st_d.flush = flush_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_req   = st_q.req;
    assign mem_octet = st_q.oa;
    assign pa_word   = st_q.pa;
    assign flush     = st_q.flush;

endmodule

// File: rtl/osq_checker.sv
module osq_checker #(
    parameter int ADDR_W = 24,
    parameter int OFS_W  = 3,
    localparam int OCT_W = ADDR_W - OFS_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              seq_start,
    input logic              hazard_refetch,
    input logic [ADDR_W-1:0] l3_addr,
    input logic              branch_far,
    input logic              target_near,
    input logic [ADDR_W-1:0] tgt_addr,
    input logic              loop_back,
    input logic              word_take,
    input logic              mem_ack,
    input logic              mem_req,
    input logic [OCT_W-1:0]  mem_octet,
    input logic [ADDR_W-1:0] pa_word,
    input logic              flush
);

    logic far_any;
    logic pa_far;
    assign far_any = seq_start || hazard_refetch || branch_far || loop_back;
    assign pa_far  = seq_start || hazard_refetch || branch_far;

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !far_any) |=> (mem_req && $stable(mem_octet)));

    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !far_any) |=> (mem_octet == $past(mem_octet) + OCT_W'(1)));

    p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
        far_any |=> flush);

    p_noflush_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !far_any |=> !flush);

    p_hazard_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hazard_refetch |=> (pa_word == $past(l3_addr) &&
                            mem_octet == $past(l3_addr[ADDR_W-1:OFS_W]) && mem_req));

    p_near_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (target_near && !pa_far) |=> (pa_word == $past(tgt_addr)));

    p_near_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (target_near && !far_any && !(mem_req && mem_ack)) |=> $stable(mem_octet));

    p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (word_take && !target_near && !pa_far && (pa_word[OFS_W-1:0] == '1))
        |=> (pa_word[OFS_W-1:0] == '0));

    p_loop_pa_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_back && !pa_far && !target_near && !word_take) |=> $stable(pa_word));

endmodule

bind octet_fetch_seq osq_checker #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) i_osq_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .seq_start      (seq_start),
    .hazard_refetch (hazard_refetch),
    .l3_addr        (l3_addr),
    .branch_far     (branch_far),
    .target_near    (target_near),
    .tgt_addr       (tgt_addr),
    .loop_back      (loop_back),
    .word_take      (word_take),
    .mem_ack        (mem_ack),
    .mem_req        (mem_req),
    .mem_octet      (mem_octet),
    .pa_word        (pa_word),
    .flush          (flush)
);

// File: tb/test_octet_fetch_seq.sv
module test_octet_fetch_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seq_start = 1'b0, hazard_refetch = 1'b0, branch_far = 1'b0;
    logic        target_near = 1'b0, loop_back = 1'b0, word_take = 1'b0, mem_ack = 1'b0;
    logic [23:0] l3_addr = '0, tgt_addr = '0;
    logic [20:0] loop_octet = '0;
    logic        mem_req, flush;
    logic [20:0] mem_octet;
    logic [23:0] pa_word;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    cmp_en = 1'b0;
    bit    done = 1'b0;
    string phase = "R1";

    // reference model state
    logic [20:0] m_la;
    logic [23:0] m_pa;
    bit          m_req, m_flush;

    always #5 clk = ~clk;

    octet_fetch_seq i_octet_fetch_seq (
        .clk(clk), .rst_n(rst_n), .seq_start(seq_start), .hazard_refetch(hazard_refetch),
        .l3_addr(l3_addr), .branch_far(branch_far), .target_near(target_near),
        .tgt_addr(tgt_addr), .loop_back(loop_back), .loop_octet(loop_octet),
        .word_take(word_take), .mem_ack(mem_ack), .mem_req(mem_req),
        .mem_octet(mem_octet), .pa_word(pa_word), .flush(flush)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_la <= '0; m_pa <= '0; m_req <= 0; m_flush <= 0;
        end else begin
            bit          far, pa_far;
            logic [23:0] waddr;
            logic [20:0] oct;
            far    = hazard_refetch || seq_start || branch_far || loop_back;
            pa_far = hazard_refetch || seq_start || branch_far;
            if (hazard_refetch || seq_start) waddr = l3_addr;
            else                             waddr = tgt_addr;
            oct = (pa_far) ? waddr[23:3] : loop_octet;
            if (far)                 m_la <= oct;
            else if (m_req && mem_ack) m_la <= m_la + 21'd1;
            if (far) m_req <= 1;
            m_flush <= far;
            if (pa_far)           m_pa <= waddr;
            else if (target_near) m_pa <= tgt_addr;
            else if (word_take)   m_pa <= (m_pa[2:0] == 3'd7) ? {m_la, 3'b000} : m_pa + 24'd1;
        end
    end

    task automatic check_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (cmp_en && !done) begin
            check_eq(phase, "mem_req", 32'(mem_req), 32'(m_req));
            check_eq(phase, "mem_octet", 32'(mem_octet), 32'(m_la));
            check_eq(phase, "pa_word", 32'(pa_word), 32'(m_pa));
            check_eq(phase, "flush", 32'(flush), 32'(m_flush));
        end
    end

    task automatic idle();
        seq_start = 0; hazard_refetch = 0; branch_far = 0; target_near = 0;
        loop_back = 0; word_take = 0; mem_ack = 0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] lf;
        lf = 32'h1ACE_B00C;
        repeat (3) step();
        cmp_en = 1'b1;
        // R1 reset values
        check_eq("R1", "mem_req", 32'(mem_req), 0);
        check_eq("R1", "mem_octet", 32'(mem_octet), 0);
        check_eq("R1", "pa_word", 32'(pa_word), 0);
        check_eq("R1", "flush", 32'(flush), 0);
        rst_n = 1'b1;
        step();

        phase = "R4"; seq_start = 1; l3_addr = 24'h000105; step(); idle();
        check_eq("R4", "mem_octet", 32'(mem_octet), 32'h20);
        check_eq("R4", "pa_word", 32'(pa_word), 32'h105);
        check_eq("R4", "mem_req", 32'(mem_req), 1);
        check_eq("R11", "flush", 32'(flush), 1);

        phase = "R3"; repeat (3) step();
        check_eq("R3", "mem_octet", 32'(mem_octet), 32'h20);
        check_eq("R11", "flush", 32'(flush), 0);

        phase = "R2"; mem_ack = 1; step(); step(); idle();
        check_eq("R2", "mem_octet", 32'(mem_octet), 32'h22);

        phase = "R8"; word_take = 1; step(); step(); step(); idle();
        check_eq("R8", "pa_word", 32'(pa_word), 32'h110);

        phase = "R7"; target_near = 1; tgt_addr = 24'h000113; step(); idle();
        check_eq("R7", "pa_word", 32'(pa_word), 32'h113);
        check_eq("R7", "mem_octet", 32'(mem_octet), 32'h22);
        check_eq("R7", "flush", 32'(flush), 0);

        phase = "R6"; branch_far = 1; tgt_addr = 24'h004000; step(); idle();
        check_eq("R6", "mem_octet", 32'(mem_octet), 32'h800);
        check_eq("R6", "pa_word", 32'(pa_word), 32'h4000);

        phase = "R5"; hazard_refetch = 1; l3_addr = 24'h002345; step(); idle();
        check_eq("R5", "mem_octet", 32'(mem_octet), 32'h468);
        check_eq("R5", "pa_word", 32'(pa_word), 32'h2345);

        phase = "R9"; loop_back = 1; loop_octet = 21'h0000AA; step(); idle();
        check_eq("R9", "mem_octet", 32'(mem_octet), 32'hAA);
        check_eq("R9", "pa_word", 32'(pa_word), 32'h2345);

        phase = "R10"; hazard_refetch = 1; branch_far = 1; loop_back = 1; target_near = 1;
        l3_addr = 24'h000700; tgt_addr = 24'h000900; step(); idle();
        check_eq("R10", "mem_octet", 32'(mem_octet), 32'hE0);
        check_eq("R10", "pa_word", 32'(pa_word), 32'h700);

        phase = "R12"; branch_far = 1; mem_ack = 1; tgt_addr = 24'h001000; step(); idle();
        check_eq("R12", "mem_octet", 32'(mem_octet), 32'h200);

        phase = "R8"; target_near = 1; tgt_addr = 24'h001007; step(); idle();
        word_take = 1; mem_ack = 1; step(); idle();
        check_eq("R8", "pa_word", 32'(pa_word), 32'h1000);
        check_eq("R2", "mem_octet", 32'(mem_octet), 32'h201);

        phase = "R10";
        for (int i = 0; i < 3000; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            hazard_refetch = (lf[4:0] == 5'd3);
            seq_start      = (lf[9:5] == 5'd7);
            branch_far     = (lf[13:10] == 4'd2);
            loop_back      = (lf[17:14] == 4'd9);
            target_near    = (lf[20:18] == 3'd1);
            word_take      = lf[21];
            mem_ack        = lf[22] | lf[23];
            l3_addr        = {lf[31:24], lf[15:0]};
            tgt_addr       = {lf[7:0], lf[31:16]};
            loop_octet     = lf[30:10];
            step();
        end
        idle();
        step();
        finish_run();
    end

endmodule